// File: doc/BRIEF.md
# Nested Vectored Interrupt Controller Core

This block holds the interrupt state of a processor: for every exception vector it keeps an enable bit, a pending bit, an active bit and a programmable 8-bit priority. Vectors 0 to 15 are internal exceptions. External interrupt lines drive vectors 16 and up. A combinational arbiter always presents the highest-priority vector that is both pending and enabled, together with that vector's group priority. The processor pulses an acknowledge to move that vector from pending to active. Later it names a vector to retire, and the block answers with a three-way completion status.

Preemption uses group priority only. The group priority is the stored priority with the subpriority bits cleared, and a programmable grouping field sets how many low bits count as subpriority. The execution priority is the lowest group priority among the active vectors, or 256 when nothing is active. An exception request is raised when the pending vector would preempt that execution priority. Vectors 1, 2 and 3 (reset, NMI, hard fault) carry the fixed negative priorities -3, -2 and -1. Each external line can be set to pulse mode or level mode.

Top module: `nvic_core`

## Requirements
- R1: After reset no vector is pending or active, `pend_valid_o` and `exc_req_o` are 0, `exec_prio_o` reads 256 and `cur_vec_o` reads 0.
- R2: Vectors 1, 2 and 3 read priority -3, -2 and -1 on `cfg_rdata_o`, and priority writes to them have no effect.
- R3: Only the top `PRIO_BITS` bits of a written priority are stored. The low bits read back as zero and take no part in arbitration.
- R4: `pend_vec_o` names the pending and enabled vector with the lowest priority value. Equal priorities go to the lower vector number. Pending vectors that are disabled are ignored, and `pend_valid_o` is 0 when no vector qualifies.
- R5: With grouping value g (op 5, data[2:0]), the group priority is the priority with bits g..0 cleared. `pend_grp_o` shows the pending vector's group priority, and negative fixed priorities pass through unchanged.
- R6: An `ack_i` pulse while `pend_valid_o` is 1 clears that vector's pending bit, sets its active bit and loads its number into `cur_vec_o`. An `ack_i` pulse with nothing pending changes nothing.
- R7: `exec_prio_o` is the lowest group priority among the active vectors, or 256 when none is active. `exc_req_o` is 1 only when `pend_grp_o` is strictly less than `exec_prio_o`.
- R8: While `cpl_req_i` is high, `cpl_status_o` reads 2'b11 if the named vector is not active (and nothing changes), 2'b01 if it is the only active vector, and 2'b00 if another vector stays active. The named vector's active bit clears at the edge.
- R9: In pulse mode (the reset mode) an external line marks its vector pending only on a rising edge. Holding the line high does not re-pend the vector after acknowledge.
- R10: In level mode (op 4, data[0]=1, vectors 16 and up only) a high line holds its vector pending while the vector is not active. If the line is still high when the vector completes, the vector is pending again at the next edge.
- R11: `rdy_o` is 1 when vector `rdy_vec_i` is enabled and its group priority is strictly less than `exec_prio_o`.
- R12: Configuration ops, applied at the clock edge when `cfg_we_i` is high: 0 writes the priority (vectors 4 and up), 1 writes the enable bit from data[0] (vectors 4 and up; vectors 2 and 3 are always enabled), 2 sets pending (vectors 2 and up; vectors 0 and 1 never pend), and 3 clears pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_VEC-16 | External interrupt lines; bit e drives vector 16+e |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_op_i | input | 3 | Configuration op code (see R12, R5, R10) |
| cfg_vec_i | input | VW | Vector addressed by the write and by the read-back |
| cfg_wdata_i | input | 8 | Write data |
| cfg_rdata_o | output | 10 | Signed effective priority of `cfg_vec_i` |
| ack_i | input | 1 | Acknowledge pulse |
| cpl_req_i | input | 1 | Completion request |
| cpl_vec_i | input | VW | Vector to complete |
| cpl_status_o | output | 2 | Completion status |
| rdy_vec_i | input | VW | Vector for the ready query |
| rdy_o | output | 1 | Ready query result |
| pend_valid_o | output | 1 | A pending and enabled vector exists |
| pend_vec_o | output | VW | Highest-priority pending vector |
| pend_grp_o | output | 10 | Signed group priority of `pend_vec_o` |
| exec_prio_o | output | 10 | Signed execution priority |
| exc_req_o | output | 1 | Exception request |
| cur_vec_o | output | VW | Vector most recently acknowledged |

## Verification
The bench builds the core with `NUM_VEC=24`, which gives eight external lines, and `PRIO_BITS=4`. With four implemented bits, written values such as 0x1F and 0x10 become equal and must then be split by vector number. This brings the masking of unimplemented bits and the tie rule into reach together. Grouping values from 0 to 7 then move the subpriority boundary below, at and above the implemented bits, so group and subpriority both come into play in the arbitration table. The small vector count keeps every external line reachable, and nested activation, strict-compare preemption and level re-pending can all be exercised within a few hundred cycles.

// File: rtl/nvic_pkg.sv
package nvic_pkg;
  localparam int PW = 8;
  localparam int SW = 10;
  localparam int FIRST_EXT = 16;
  typedef logic signed [SW-1:0] sprio_t;
  localparam sprio_t PRIO_IDLE = 10'sd256;

  typedef enum logic [2:0] {
    OP_PRIO    = 3'd0,
    OP_ENABLE  = 3'd1,
    OP_SETPEND = 3'd2,
    OP_CLRPEND = 3'd3,
    OP_LEVEL   = 3'd4,
    OP_GROUP   = 3'd5
  } cfg_op_e;

  typedef enum logic [1:0] {
    CPL_NESTED = 2'b00,
    CPL_BASE   = 2'b01,
    CPL_NOTACT = 2'b11
  } cpl_e;

  // mask keeping only the implemented high-order priority bits
  function automatic logic [PW-1:0] impl_mask(input int bits);
    logic [PW-1:0] low;
    low = PW'((1 << (PW - bits)) - 1);
    return ~low;
  endfunction

  // fixed priorities of vectors 1..3, others report zero here
  function automatic sprio_t fixed_prio(input int v);
    case (v)
      1: return -10'sd3;
      2: return -10'sd2;
      3: return -10'sd1;
      default: return '0;
    endcase
  endfunction

  // group priority: clear bits g..0 of a non-negative priority
  function automatic sprio_t group_of(input sprio_t p, input logic [2:0] g);
    logic [SW-1:0] m;
    if (p < 0) return p;
    m = SW'((2 << g) - 1);
    return sprio_t'(p & ~m);
  endfunction
endpackage

// File: rtl/nvic_src.sv
module nvic_src (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_i,
  input  logic level_i,
  input  logic act_i,
  input  logic cpl_i,
  output logic set_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= irq_i;
  end

  logic rise;
  assign rise  = irq_i && !prev_q;
  assign set_o = level_i ? (irq_i && (!act_i || cpl_i)) : rise;

  // R9
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_i && prev_q && irq_i) |-> !set_o);
endmodule

// File: rtl/nvic_arb.sv
module nvic_arb #(
  parameter int N  = 48,
  parameter int VW = $clog2(N)
) (
  input  logic                 req_i [N],
  input  nvic_pkg::sprio_t     key_i [N],
  output logic                 valid_o,
  output logic [VW-1:0]        idx_o
);
  nvic_pkg::sprio_t best;

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && (!valid_o || key_i[i] < best)) begin
        valid_o = 1'b1;
        idx_o   = VW'(i);
        best    = key_i[i];
      end
    end
  end
endmodule

// File: rtl/nvic_core.sv
module nvic_core #(
  parameter int NUM_VEC   = 48,
  parameter int PRIO_BITS = 8,
  parameter int VW        = $clog2(NUM_VEC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_VEC-17:0]     irq_i,
  input  logic                    cfg_we_i,
  input  logic [2:0]              cfg_op_i,
  input  logic [VW-1:0]           cfg_vec_i,
  input  logic [7:0]              cfg_wdata_i,
  output logic signed [9:0]       cfg_rdata_o,
  input  logic                    ack_i,
  input  logic                    cpl_req_i,
  input  logic [VW-1:0]           cpl_vec_i,
  output logic [1:0]              cpl_status_o,
  input  logic [VW-1:0]           rdy_vec_i,
  output logic                    rdy_o,
  output logic                    pend_valid_o,
  output logic [VW-1:0]           pend_vec_o,
  output logic signed [9:0]       pend_grp_o,
  output logic signed [9:0]       exec_prio_o,
  output logic                    exc_req_o,
  output logic [VW-1:0]           cur_vec_o
);
  import nvic_pkg::*;

  localparam int NUM_EXT = NUM_VEC - FIRST_EXT;
  localparam logic [PW-1:0] IMPL = impl_mask(PRIO_BITS);
  localparam logic [NUM_VEC-1:0] ALWAYS_EN = NUM_VEC'(4'b1100);

  logic [PW-1:0]      prio_q [NUM_VEC];
  logic [NUM_VEC-1:0] en_q, pend_q, act_q, pend_d, act_d, src_set, eff_en;
  logic [NUM_EXT-1:0] lvl_q;
  logic [2:0]         grp_q;
  sprio_t             eff_prio [NUM_VEC];
  sprio_t             grp_prio [NUM_VEC];
  logic               elig [NUM_VEC];

  cfg_op_e op;
  assign op = cfg_op_e'(cfg_op_i);

  logic cfg_ok, cpl_ok, rdy_ok;
  assign cfg_ok = int'(cfg_vec_i) < NUM_VEC;
  assign cpl_ok = int'(cpl_vec_i) < NUM_VEC;
  assign rdy_ok = int'(rdy_vec_i) < NUM_VEC;

  // effective and group priorities per vector
  always_comb begin
    for (int v = 0; v < NUM_VEC; v++) begin
      eff_prio[v] = (v >= 1 && v <= 3) ? fixed_prio(v) : sprio_t'({2'b00, prio_q[v]});
      grp_prio[v] = group_of(eff_prio[v], grp_q);
    end
  end

  assign eff_en = en_q | ALWAYS_EN;
  always_comb begin
    for (int v = 0; v < NUM_VEC; v++) elig[v] = pend_q[v] && eff_en[v];
  end

  // arbitration: full priority, lower number on ties
  nvic_arb #(.N(NUM_VEC), .VW(VW)) u_arb (
    .req_i   (elig),
    .key_i   (eff_prio),
    .valid_o (pend_valid_o),
    .idx_o   (pend_vec_o)
  );
  assign pend_grp_o = pend_valid_o ? grp_prio[pend_vec_o] : PRIO_IDLE;

  // execution priority from the active set
  always_comb begin
    exec_prio_o = PRIO_IDLE;
    for (int v = 0; v < NUM_VEC; v++)
      if (act_q[v] && grp_prio[v] < exec_prio_o) exec_prio_o = grp_prio[v];
  end

  assign exc_req_o   = pend_valid_o && (pend_grp_o < exec_prio_o);
  assign rdy_o       = rdy_ok && eff_en[rdy_vec_i] && (grp_prio[rdy_vec_i] < exec_prio_o);
  assign cfg_rdata_o = cfg_ok ? eff_prio[cfg_vec_i] : '0;

  // internal events
  logic ack_fire, cpl_fire;
  assign ack_fire = ack_i && pend_valid_o;
  assign cpl_fire = cpl_req_i && cpl_ok && act_q[cpl_vec_i];

  always_comb begin
    if (!cpl_fire)                  cpl_status_o = CPL_NOTACT;
    else if ($countones(act_q) == 1) cpl_status_o = CPL_BASE;
    else                            cpl_status_o = CPL_NESTED;
  end

  // interrupt sources
  assign src_set[FIRST_EXT-1:0] = '0;
  for (genvar e = 0; e < NUM_EXT; e++) begin : g_src
    nvic_src u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .irq_i   (irq_i[e]),
      .level_i (lvl_q[e]),
      .act_i   (act_q[FIRST_EXT+e]),
      .cpl_i   (cpl_fire && int'(cpl_vec_i) == FIRST_EXT + e),
      .set_o   (src_set[FIRST_EXT+e])
    );
  end

  // next pending / active state; acknowledge is applied last
  always_comb begin
    pend_d = pend_q | src_set;
    act_d  = act_q;
    if (cfg_we_i && cfg_ok && op == OP_SETPEND && int'(cfg_vec_i) >= 2) pend_d[cfg_vec_i] = 1'b1;
    if (cfg_we_i && cfg_ok && op == OP_CLRPEND) pend_d[cfg_vec_i] = 1'b0;
    if (cpl_fire) act_d[cpl_vec_i] = 1'b0;
    if (ack_fire) begin
      pend_d[pend_vec_o] = 1'b0;
      act_d[pend_vec_o]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      act_q     <= '0;
      en_q      <= '0;
      lvl_q     <= '0;
      grp_q     <= '0;
      cur_vec_o <= '0;
      for (int v = 0; v < NUM_VEC; v++) prio_q[v] <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      if (ack_fire) cur_vec_o <= pend_vec_o;
      if (cfg_we_i && cfg_ok) begin
        if (op == OP_PRIO && int'(cfg_vec_i) >= 4) prio_q[cfg_vec_i] <= cfg_wdata_i & IMPL;
        if (op == OP_ENABLE && int'(cfg_vec_i) >= 4) en_q[cfg_vec_i] <= cfg_wdata_i[0];
        if (op == OP_LEVEL && int'(cfg_vec_i) >= FIRST_EXT)
          lvl_q[int'(cfg_vec_i) - FIRST_EXT] <= cfg_wdata_i[0];
      end
      if (cfg_we_i && op == OP_GROUP) grp_q <= cfg_wdata_i[2:0];
    end
  end

  // R6
  ack_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (act_q[$past(pend_vec_o)] && !pend_q[$past(pend_vec_o)]
                  && cur_vec_o == $past(pend_vec_o)));

  // R8
  cpl_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_req_i && !cpl_fire && !ack_fire) |=> act_q == $past(act_q));

  // R8
  cpl_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_fire && cpl_status_o == CPL_BASE && !ack_fire) |=> act_q == '0);

  // R7
  idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == '0) |-> exec_prio_o == PRIO_IDLE);

  // R4
  winner_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o |-> (pend_q[pend_vec_o] && eff_en[pend_vec_o]));
endmodule

// File: tb/sim_nvic_core.sv
module sim_nvic_core;
  localparam int NV = 24;
  localparam int PB = 4;
  localparam int VW = $clog2(NV);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [NV-17:0] irq;
  logic cfg_we, ack, cpl_req;
  logic [2:0] cfg_op;
  logic [VW-1:0] cfg_vec, cpl_vec, rdy_vec, pend_vec, cur_vec;
  logic [7:0] cfg_wdata;
  logic signed [9:0] cfg_rdata, pend_grp, exec_prio;
  logic [1:0] cpl_status;
  logic rdy, pend_valid, exc_req;

  nvic_core #(.NUM_VEC(NV), .PRIO_BITS(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_we_i(cfg_we), .cfg_op_i(cfg_op),
    .cfg_vec_i(cfg_vec), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .ack_i(ack), .cpl_req_i(cpl_req), .cpl_vec_i(cpl_vec), .cpl_status_o(cpl_status),
    .rdy_vec_i(rdy_vec), .rdy_o(rdy), .pend_valid_o(pend_valid), .pend_vec_o(pend_vec),
    .pend_grp_o(pend_grp), .exec_prio_o(exec_prio), .exc_req_o(exc_req), .cur_vec_o(cur_vec)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // bench's own restatement of the grouping arithmetic
  function automatic int exp_grp(input int p, input int g);
    int q, step;
    q = (p / (2 ** (8 - PB))) * (2 ** (8 - PB));
    step = 2 ** (g + 1);
    return (q / step) * step;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq = '0; cfg_we = 0; cfg_op = 0; cfg_vec = 0; cfg_wdata = 0;
    ack = 0; cpl_req = 0; cpl_vec = 0; rdy_vec = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic cfg(input int op, input int v, input int d);
    cfg_we = 1; cfg_op = 3'(op); cfg_vec = VW'(v); cfg_wdata = 8'(d);
    tick();
    cfg_we = 0;
  endtask

  task automatic pulse(input int v);
    irq[v-16] = 1'b1;
    tick();
    irq[v-16] = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic do_cpl(input int v, input int exp_status, input string req);
    cpl_req = 1; cpl_vec = VW'(v);
    #1;
    chk(req, int'(cpl_status), exp_status);
    tick();
    cpl_req = 0;
  endtask

  // arbitration table: group, vector a, prio a, vector b, prio b, winner
  localparam int ROWS = 6;
  localparam int TG [ROWS] = '{7, 7, 4, 0, 2, 5};
  localparam int TVA[ROWS] = '{16, 18, 21, 17, 23, 20};
  localparam int TPA[ROWS] = '{8'h80, 8'h40, 8'h30, 8'h1F, 8'hF0, 8'h70};
  localparam int TVB[ROWS] = '{17, 20, 19, 16, 22, 16};
  localparam int TPB[ROWS] = '{8'h40, 8'h40, 8'h20, 8'h10, 8'h00, 8'h90};
  localparam int TW [ROWS] = '{17, 18, 19, 16, 22, 20};

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 pend_valid", pend_valid, 0);
    chk("R1 exc_req", exc_req, 0);
    chk("R1 exec_prio", exec_prio, 256);
    chk("R1 cur_vec", cur_vec, 0);

    // R4 R5 arbitration table
    for (int r = 0; r < ROWS; r++) begin
      int wp;
      do_reset();
      cfg(5, 0, TG[r]);
      cfg(0, TVA[r], TPA[r]);
      cfg(0, TVB[r], TPB[r]);
      cfg(1, TVA[r], 1);
      cfg(1, TVB[r], 1);
      irq[TVA[r]-16] = 1'b1; irq[TVB[r]-16] = 1'b1;
      tick();
      irq = '0;
      wp = (TW[r] == TVA[r]) ? TPA[r] : TPB[r];
      chk($sformatf("R4 row %0d winner", r), pend_vec, TW[r]);
      chk($sformatf("R5 row %0d group", r), pend_grp, exp_grp(wp, TG[r]));
    end

    // R2 fixed priorities, R3 masking
    do_reset();
    cfg_vec = 1; #1; chk("R2 reset prio", cfg_rdata, -3);
    cfg_vec = 2; #1; chk("R2 nmi prio", cfg_rdata, -2);
    cfg_vec = 3; #1; chk("R2 hardfault prio", cfg_rdata, -1);
    tick();
    cfg(0, 2, 8'h50);
    cfg_vec = 2; #1; chk("R2 nmi write ignored", cfg_rdata, -2);
    tick();
    cfg(0, 16, 8'hAB);
    cfg_vec = 16; #1; chk("R3 low bits zero", cfg_rdata, 8'hA0);
    tick();

    // R4 disabled vector is ignored
    pulse(16);
    chk("R4 disabled ignored", pend_valid, 0);
    // R6 ack with nothing pending
    do_ack();
    chk("R6 idle ack cur_vec", cur_vec, 0);
    chk("R6 idle ack exec", exec_prio, 256);

    // R6 R7 R8 R11 nesting
    do_reset();
    cfg(5, 0, 3);
    cfg(0, 16, 8'h80); cfg(0, 17, 8'h40); cfg(0, 18, 8'h40);
    cfg(1, 16, 1); cfg(1, 17, 1); cfg(1, 18, 1);
    pulse(16);
    chk("R4 single pend", pend_vec, 16);
    chk("R7 req from idle", exc_req, 1);
    do_ack();
    chk("R6 cur_vec", cur_vec, 16);
    chk("R6 pending cleared", pend_valid, 0);
    chk("R7 exec one active", exec_prio, 8'h80);
    pulse(17);
    chk("R7 preempt req", exc_req, 1);
    do_ack();
    chk("R7 exec nested", exec_prio, 8'h40);
    pulse(18);
    chk("R7 equal group no req", exc_req, 0);
    rdy_vec = 18; #1; chk("R11 equal not ready", rdy, 0);
    do_cpl(20, 3, "R8 not active status");
    chk("R8 not active no change", exec_prio, 8'h40);
    do_cpl(17, 0, "R8 nested status");
    chk("R8 exec after retire", exec_prio, 8'h80);
    chk("R7 req after retire", exc_req, 1);
    rdy_vec = 18; #1; chk("R11 ready", rdy, 1);
    rdy_vec = 19; #1; chk("R11 disabled not ready", rdy, 0);
    do_cpl(16, 1, "R8 base status");
    chk("R8 idle again", exec_prio, 256);

    // R12 set/clear pending, fixed negative priority
    cfg(2, 2, 0);
    chk("R12 nmi pend", pend_vec, 2);
    chk("R5 negative group", pend_grp, -2);
    cfg(3, 2, 0);
    chk("R12 clear pend", pend_vec, 18);
    cfg(2, 1, 0);
    chk("R12 vector 1 never pends", pend_vec, 18);
    cfg(0, 5, 8'h10); cfg(1, 5, 1); cfg(2, 5, 0);
    chk("R12 internal pend", pend_vec, 5);

    // R9 pulse mode
    do_reset();
    cfg(1, 16, 1);
    irq[0] = 1'b1;
    tick();
    chk("R9 rising edge pends", pend_vec, 16);
    do_ack();
    tick(); tick();
    chk("R9 held line no repend", pend_valid, 0);
    irq[0] = 1'b0;

    // R10 level mode
    do_reset();
    cfg(4, 17, 1); cfg(1, 17, 1);
    irq[1] = 1'b1;
    tick();
    chk("R10 level pends", pend_vec, 17);
    do_ack();
    tick();
    chk("R10 active no pend", pend_valid, 0);
    do_cpl(17, 1, "R10 base status");
    chk("R10 repend on completion", pend_valid, 1);
    chk("R10 repend vector", pend_vec, 17);
    irq[1] = 1'b0;
    do_ack();
    do_cpl(17, 1, "R10 second completion");
    chk("R10 low line no repend", pend_valid, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule